// File: doc/BRIEF.md
# Data-cache line coherence state controller

This block keeps the coherence state of every line in a four-way, 128-set data cache. Each line is Invalid, Exclusive (valid and clean) or Modified (valid and dirty), and the block keeps a 20-bit tag for each line. Two kinds of event reach it. Core loads and stores arrive with a write-through or write-back attribute and a victim way chosen by an outside replacement unit. Snooped global accesses from another bus master arrive with a flag that says whether that master will cache the line.

For each accepted event the block looks up the set. It updates the tag and state storage at the same clock edge. In the next cycle it presents one action record that tells the surrounding logic what to do: return hit data, read from memory without caching, start a line fill, push a dirty victim to the write buffer, write to memory, write to the cache array, or push a snooped dirty line. The record also carries the resulting line state. The burst engine, the replacement choice and the data array sit outside this block.

Core requests and snoops each use a valid/ready handshake. Actions leave on a valid/ready handshake. While an action is held because `act_ready` is low, both request ports show ready low and the action fields stay fixed. When a snoop and a core request are both valid, the snoop is taken first. The core request waits with ready low and must keep its fields stable until it is accepted.

Top module: `mei_dcache_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 00; 01 is Exclusive, 10 is Modified), no action is valid, and the first load to any line is a miss.
- R2: A load that hits returns an action with the hit and read-hit flags set, the hit way, and the line state unchanged.
- R3: A load miss starts a fill into the supplied victim way and installs the line as Exclusive. If the victim was Modified, the action also asserts victim push and carries the victim's old tag. The victim tag field is zero when there is no push.
- R4: A write-through store hit writes both the cache and memory and leaves the line state as it was.
- R5: A write-through store miss writes memory only and allocates no line, so a later load to that line still misses.
- R6: A write-back store hit writes only the cache and makes the line Modified.
- R7: A write-back store miss pushes a Modified victim, fills the victim way, writes the cache, and installs the line as Modified.
- R8: A snoop that misses produces no action and changes no state.
- R9: A snoop that hits a Modified line asserts snoop push. The line becomes Invalid if the other master will cache it, and Exclusive otherwise.
- R10: A snoop that hits an Exclusive line makes it Invalid if the other master will cache it, and leaves it Exclusive otherwise, with no push.
- R11: A flash-invalidate cycle holds both request readies low and leaves every line Invalid.
- R12: While the cache enable is low, a load gives a memory-read action and a store gives a memory-write action, with no hit, fill or cache write, and no state change.
- R13: When a snoop and a core request are valid in the same cycle, the snoop is accepted first and the core request sees ready low.
- R14: While an action is valid and not accepted, the action fields stay stable and neither request port is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Cache enable; low makes core accesses bypass the cache |
| flash_inv | input | 1 | Clears every line to Invalid at the clock edge |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request accepted at this edge |
| req_store | input | 1 | 1 = store, 0 = load |
| req_wt | input | 1 | 1 = write-through page, 0 = write-back page |
| req_line | input | 27 | Line address: tag in [26:7], set in [6:0] |
| req_victim | input | 2 | Way to replace on an allocating miss |
| snp_valid | input | 1 | Snooped global access valid |
| snp_ready | output | 1 | Snoop accepted at this edge |
| snp_line | input | 27 | Snooped line address, same layout as req_line |
| snp_will_cache | input | 1 | Other master will cache the line |
| act_valid | output | 1 | Action record valid |
| act_ready | input | 1 | Consumer takes the action |
| act_snoop | output | 1 | Action came from a snoop |
| act_hit | output | 1 | Lookup hit |
| act_way | output | 2 | Hit way on a hit, otherwise the supplied victim way |
| act_read_hit | output | 1 | Return data from the cache |
| act_fill | output | 1 | Start a burst line fill |
| act_victim_push | output | 1 | Move the Modified victim to the write buffer |
| act_victim_tag | output | 20 | Tag of the pushed victim, zero otherwise |
| act_mem_read | output | 1 | Uncached read from memory |
| act_mem_write | output | 1 | Write the store data to memory |
| act_cache_write | output | 1 | Write the store data to the cache array |
| act_snoop_push | output | 1 | Push the snooped Modified line to memory |
| act_state | output | 2 | Resulting line state (00 I, 01 E, 10 M) |
| act_line | output | 27 | Line address of the event |

## Verification
An event is taken at the rising edge where its valid and ready are both high. Its action and any state change are visible from that edge onward, so the bench drives inputs at falling edges and compares the whole action record 1 ns after the accepting edge. The bench checks snoop priority and flash blocking on the ready outputs after inputs settle, before the edge. For back-pressure, the bench records the action, stalls the consumer, and compares the held record one edge later. It compares the next request's action only after the edge where that request is finally accepted.

// File: rtl/mei_pkg.sv
package mei_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_E = 2'b01,
    ST_M = 2'b10
  } mei_state_e;

  typedef struct packed {
    logic       hit;
    logic       read_hit;
    logic       fill;
    logic       push;
    logic       mem_rd;
    logic       mem_wr;
    logic       cache_wr;
    logic       snoop_push;
    mei_state_e state;
    logic       install;
    logic       upd;
  } mei_decision_t;

endpackage

// File: rtl/mei_tag_store.sv
module mei_tag_store
  import mei_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flash,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
  output mei_state_e [WAYS-1:0]       rd_states,
  input  logic                        wr_en,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic                        wr_tag_en,
  input  logic [TAG_W-1:0]            wr_tag,
  input  mei_state_e                  wr_state
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    mei_state_e       st_q  [SETS];
    logic             sel;

    assign sel = wr_en && (wr_way == WAY_W'(w));

    // state bits: cleared by reset and by flash invalidate
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) st_q[s] <= ST_I;
      end else if (flash) begin
        for (int s = 0; s < SETS; s++) st_q[s] <= ST_I;
      end else if (sel) begin
        st_q[wr_set] <= wr_state;
      end
    end

    // tags are only meaningful behind a valid state
    always_ff @(posedge clk) begin
      if (sel && wr_tag_en) tag_q[wr_set] <= wr_tag;
    end

    assign rd_tags[w]   = tag_q[rd_set];
    assign rd_states[w] = st_q[rd_set];
  end

endmodule

// File: rtl/mei_lookup.sv
module mei_lookup
  import mei_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  mei_state_e [WAYS-1:0]      states,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output mei_state_e                 hit_state
);

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = (states[w] != ST_I) && (tags[w] == tag);
  end

  // lowest matching way wins; only one can match in a consistent store
  always_comb begin
    hit       = 1'b0;
    hit_way   = '0;
    hit_state = ST_I;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit       = 1'b1;
        hit_way   = WAY_W'(w);
        hit_state = states[w];
      end
    end
  end

endmodule

// File: rtl/mei_policy.sv
module mei_policy
  import mei_pkg::*;
(
  input  logic          is_snoop,
  input  logic          cache_en,
  input  logic          store,
  input  logic          wt,
  input  logic          will_cache,
  input  logic          hit,
  input  mei_state_e    hit_state,
  input  mei_state_e    victim_state,
  output mei_decision_t dec
);

  always_comb begin
    dec       = '0;
    dec.state = ST_I;
    if (is_snoop) begin
      if (hit) begin
        dec.hit        = 1'b1;
        dec.snoop_push = (hit_state == ST_M);
        dec.state      = will_cache ? ST_I : ST_E;
        dec.upd        = 1'b1;
      end
    end else if (!cache_en) begin
      dec.mem_rd = !store;
      dec.mem_wr = store;
    end else if (!store) begin
      if (hit) begin
        dec.hit      = 1'b1;
        dec.read_hit = 1'b1;
        dec.state    = hit_state;
      end else begin
        dec.fill    = 1'b1;
        dec.push    = (victim_state == ST_M);
        dec.state   = ST_E;
        dec.install = 1'b1;
        dec.upd     = 1'b1;
      end
    end else if (wt) begin
      if (hit) begin
        dec.hit      = 1'b1;
        dec.cache_wr = 1'b1;
        dec.mem_wr   = 1'b1;
        dec.state    = hit_state;
      end else begin
        dec.mem_wr = 1'b1;
      end
    end else begin
      if (hit) begin
        dec.hit      = 1'b1;
        dec.cache_wr = 1'b1;
        dec.state    = ST_M;
        dec.upd      = 1'b1;
      end else begin
        dec.fill     = 1'b1;
        dec.push     = (victim_state == ST_M);
        dec.cache_wr = 1'b1;
        dec.state    = ST_M;
        dec.install  = 1'b1;
        dec.upd      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mei_dcache_ctrl.sv
module mei_dcache_ctrl
  import mei_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINE_W = TAG_W + SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              flash_inv,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic              req_wt,
  input  logic [LINE_W-1:0] req_line,
  input  logic [WAY_W-1:0]  req_victim,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic [LINE_W-1:0] snp_line,
  input  logic              snp_will_cache,
  output logic              act_valid,
  input  logic              act_ready,
  output logic              act_snoop,
  output logic              act_hit,
  output logic [WAY_W-1:0]  act_way,
  output logic              act_read_hit,
  output logic              act_fill,
  output logic              act_victim_push,
  output logic [TAG_W-1:0]  act_victim_tag,
  output logic              act_mem_read,
  output logic              act_mem_write,
  output logic              act_cache_write,
  output logic              act_snoop_push,
  output logic [1:0]        act_state,
  output logic [LINE_W-1:0] act_line
);

  logic                       can_take, snp_go, req_go, emit;
  logic [LINE_W-1:0]          sel_line;
  logic [TAG_W-1:0]           sel_tag;
  logic [SET_W-1:0]           sel_set;
  logic [WAYS-1:0][TAG_W-1:0] rd_tags;
  mei_state_e [WAYS-1:0]      rd_states;
  logic                       lk_hit;
  logic [WAY_W-1:0]           lk_way;
  mei_state_e                 lk_state;
  mei_decision_t              dec;
  logic [WAY_W-1:0]           wr_way;

  // output stage frees up when empty or being drained
  assign can_take  = !act_valid || act_ready;
  assign snp_ready = can_take && !flash_inv;
  assign req_ready = can_take && !flash_inv && !snp_valid;
  assign snp_go    = snp_valid && snp_ready;
  assign req_go    = req_valid && req_ready;

  // one lookup port, owned by the snoop whenever one is pending
  assign sel_line = snp_valid ? snp_line : req_line;
  assign sel_tag  = sel_line[LINE_W-1:SET_W];
  assign sel_set  = sel_line[SET_W-1:0];

  mei_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flash     (flash_inv),
    .rd_set    (sel_set),
    .rd_tags   (rd_tags),
    .rd_states (rd_states),
    .wr_en     ((snp_go || req_go) && dec.upd),
    .wr_set    (sel_set),
    .wr_way    (wr_way),
    .wr_tag_en (dec.install),
    .wr_tag    (sel_tag),
    .wr_state  (dec.state)
  );

  mei_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
    .tags      (rd_tags),
    .states    (rd_states),
    .tag       (sel_tag),
    .hit       (lk_hit),
    .hit_way   (lk_way),
    .hit_state (lk_state)
  );

  mei_policy u_policy (
    .is_snoop     (snp_valid),
    .cache_en     (cache_en),
    .store        (req_store),
    .wt           (req_wt),
    .will_cache   (snp_will_cache),
    .hit          (lk_hit),
    .hit_state    (lk_state),
    .victim_state (rd_states[req_victim]),
    .dec          (dec)
  );

  assign wr_way = dec.install ? req_victim : lk_way;
  assign emit   = snp_go ? lk_hit : req_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
    end else if (can_take) begin
      act_valid <= emit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_snoop       <= 1'b0;
      act_hit         <= 1'b0;
      act_way         <= '0;
      act_read_hit    <= 1'b0;
      act_fill        <= 1'b0;
      act_victim_push <= 1'b0;
      act_victim_tag  <= '0;
      act_mem_read    <= 1'b0;
      act_mem_write   <= 1'b0;
      act_cache_write <= 1'b0;
      act_snoop_push  <= 1'b0;
      act_state       <= ST_I;
      act_line        <= '0;
    end else if (can_take && emit) begin
      act_snoop       <= snp_go;
      act_hit         <= dec.hit;
      act_way         <= dec.hit ? lk_way : req_victim;
      act_read_hit    <= dec.read_hit;
      act_fill        <= dec.fill;
      act_victim_push <= dec.push;
      act_victim_tag  <= dec.push ? rd_tags[req_victim] : '0;
      act_mem_read    <= dec.mem_rd;
      act_mem_write   <= dec.mem_wr;
      act_cache_write <= dec.cache_wr;
      act_snoop_push  <= dec.snoop_push;
      act_state       <= dec.state;
      act_line        <= sel_line;
    end
  end

endmodule

// File: rtl/mei_dcache_ctrl_chk.sv
module mei_dcache_ctrl_chk #(
  parameter int WAY_W  = 2,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cache_en,
  input logic              flash_inv,
  input logic              req_valid,
  input logic              req_ready,
  input logic              snp_valid,
  input logic              snp_ready,
  input logic              act_valid,
  input logic              act_ready,
  input logic              act_snoop,
  input logic              act_hit,
  input logic [WAY_W-1:0]  act_way,
  input logic              act_read_hit,
  input logic              act_fill,
  input logic              act_victim_push,
  input logic [TAG_W-1:0]  act_victim_tag,
  input logic              act_mem_read,
  input logic              act_mem_write,
  input logic              act_cache_write,
  input logic              act_snoop_push,
  input logic [1:0]        act_state,
  input logic [LINE_W-1:0] act_line
);

  // R11
  flash_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_inv |-> !req_ready && !snp_ready);

  // R13
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !req_ready);

  // R14
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && !act_ready |=> act_valid && $stable({act_snoop, act_hit, act_way,
      act_read_hit, act_fill, act_victim_push, act_victim_tag, act_mem_read,
      act_mem_write, act_cache_write, act_snoop_push, act_state, act_line}));

  // R14
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && !act_ready |-> !req_ready && !snp_ready);

  // R12
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !cache_en |=> act_valid && !act_hit && !act_fill
      && !act_cache_write && (act_mem_read != act_mem_write));

  // R3
  push_with_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_victim_push |-> act_fill && !act_snoop);

  // R9
  snoop_push_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_snoop_push |-> act_snoop && act_hit && !act_fill);

  // R2
  read_hit_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_read_hit |-> act_hit && act_state != 2'b00 && act_state != 2'b11);

endmodule

bind mei_dcache_ctrl mei_dcache_ctrl_chk #(
  .WAY_W(WAY_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flash_inv(flash_inv),
  .req_valid(req_valid), .req_ready(req_ready), .snp_valid(snp_valid),
  .snp_ready(snp_ready), .act_valid(act_valid), .act_ready(act_ready),
  .act_snoop(act_snoop), .act_hit(act_hit), .act_way(act_way),
  .act_read_hit(act_read_hit), .act_fill(act_fill),
  .act_victim_push(act_victim_push), .act_victim_tag(act_victim_tag),
  .act_mem_read(act_mem_read), .act_mem_write(act_mem_write),
  .act_cache_write(act_cache_write), .act_snoop_push(act_snoop_push),
  .act_state(act_state), .act_line(act_line)
);

// File: tb/mei_dcache_ctrl_test.sv
`timescale 1ns/1ps
module mei_dcache_ctrl_test;

  localparam int CLK_NS = 8;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic rst_n, cache_en, flash_inv;
  logic req_valid, req_ready, req_store, req_wt;
  logic [26:0] req_line;
  logic [1:0]  req_victim;
  logic snp_valid, snp_ready, snp_will_cache;
  logic [26:0] snp_line;
  logic act_valid, act_ready, act_snoop, act_hit, act_read_hit, act_fill;
  logic [1:0]  act_way, act_state;
  logic act_victim_push, act_mem_read, act_mem_write, act_cache_write, act_snoop_push;
  logic [19:0] act_victim_tag;
  logic [26:0] act_line;

  mei_dcache_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flash_inv(flash_inv),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_wt(req_wt), .req_line(req_line), .req_victim(req_victim),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_line(snp_line),
    .snp_will_cache(snp_will_cache), .act_valid(act_valid), .act_ready(act_ready),
    .act_snoop(act_snoop), .act_hit(act_hit), .act_way(act_way),
    .act_read_hit(act_read_hit), .act_fill(act_fill),
    .act_victim_push(act_victim_push), .act_victim_tag(act_victim_tag),
    .act_mem_read(act_mem_read), .act_mem_write(act_mem_write),
    .act_cache_write(act_cache_write), .act_snoop_push(act_snoop_push),
    .act_state(act_state), .act_line(act_line)
  );

  int checks = 0;
  int errors = 0;
  bit model_en = 1'b1;
  logic [1:0]  mst  [128][4];
  logic [19:0] mtag [128][4];

  function automatic logic [59:0] observed();
    return {act_snoop, act_hit, act_way, act_read_hit, act_fill, act_victim_push,
            act_victim_tag, act_mem_read, act_mem_write, act_cache_write,
            act_snoop_push, act_state, act_line};
  endfunction

  task automatic check(input string r, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, got, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // expected action from the requirements; updates the reference state
  task automatic predict(input bit snp, input bit st, input bit wt, input bit will,
                         input logic [26:0] line, input logic [1:0] vic,
                         output bit emit, output logic [59:0] exp, output string lbl);
    logic [6:0]  set = line[6:0];
    logic [19:0] tag = line[26:7];
    bit hit = 0, h = 0, rd = 0, fill = 0, push = 0, mrd = 0, mwr = 0, cwr = 0, spush = 0, inst = 0;
    logic [1:0]  hw = 0, way = vic, nst = 2'b00;
    logic [19:0] vtag = 0;
    for (int w = 3; w >= 0; w--)
      if (mst[set][w] != 2'b00 && mtag[set][w] == tag) begin hit = 1; hw = 2'(w); end
    emit = 1;
    if (snp) begin
      lbl = "R8";
      emit = hit;
      if (hit) begin
        lbl = (mst[set][hw] == 2'b10) ? "R9" : "R10";
        spush = (mst[set][hw] == 2'b10);
        nst = will ? 2'b00 : 2'b01;
        mst[set][hw] = nst;
        h = 1; way = hw;
      end
    end else if (!model_en) begin
      lbl = "R12"; mrd = !st; mwr = st;
    end else begin
      h = hit; if (hit) way = hw;
      if (!st) begin
        if (hit) begin lbl = "R2"; rd = 1; nst = mst[set][hw]; end
        else begin lbl = "R3"; fill = 1; nst = 2'b01; inst = 1; end
      end else if (wt) begin
        if (hit) begin lbl = "R4"; cwr = 1; mwr = 1; nst = mst[set][hw]; end
        else begin lbl = "R5"; mwr = 1; end
      end else begin
        if (hit) begin lbl = "R6"; cwr = 1; nst = 2'b10; mst[set][hw] = 2'b10; end
        else begin lbl = "R7"; fill = 1; cwr = 1; nst = 2'b10; inst = 1; end
      end
      if (inst) begin
        push = (mst[set][vic] == 2'b10);
        if (push) vtag = mtag[set][vic];
        mst[set][vic] = nst; mtag[set][vic] = tag;
      end
    end
    exp = {snp, h, way, rd, fill, push, vtag, mrd, mwr, cwr, spush, nst, line};
  endtask

  task automatic core_op(input bit st, input bit wt, input logic [26:0] line, input logic [1:0] vic);
    bit emit; logic [59:0] exp; string lbl;
    @(negedge clk);
    req_valid = 1; req_store = st; req_wt = wt; req_line = line; req_victim = vic;
    predict(0, st, wt, 0, line, vic, emit, exp, lbl);
    @(posedge clk); #1;
    req_valid = 0;
    check(lbl, {3'b0, act_valid, observed()}, {3'b0, 1'b1, exp});
  endtask

  task automatic snoop_op(input logic [26:0] line, input bit will);
    bit emit; logic [59:0] exp; string lbl;
    @(negedge clk);
    snp_valid = 1; snp_line = line; snp_will_cache = will;
    predict(1, 0, 0, will, line, 0, emit, exp, lbl);
    @(posedge clk); #1;
    snp_valid = 0;
    if (emit) check(lbl, {3'b0, act_valid, observed()}, {3'b0, 1'b1, exp});
    else      check(lbl, {63'b0, act_valid}, 64'b0);
  endtask

  function automatic logic [26:0] mk(input int tag, input int set);
    return {20'(tag), 7'(set)};
  endfunction

  initial begin
    #(CLK_NS * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    bit emit; logic [59:0] exp, snap; string lbl;
    void'($urandom(32'h1c0de));
    for (int s = 0; s < 128; s++) for (int w = 0; w < 4; w++) begin mst[s][w] = 0; mtag[s][w] = 0; end
    rst_n = 0; cache_en = 1; flash_inv = 0; act_ready = 1;
    req_valid = 0; req_store = 0; req_wt = 0; req_line = 0; req_victim = 0;
    snp_valid = 0; snp_line = 0; snp_will_cache = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 act_valid in reset", {63'b0, act_valid}, 64'b0);
    @(negedge clk); rst_n = 1;
    #1 check("R1 ready after reset", {62'b0, req_ready, snp_ready}, 64'd3);

    // first load is a miss; then hit; then dirty; then dirty victim is pushed
    core_op(0, 0, mk(5, 9), 0);
    core_op(0, 0, mk(5, 9), 1);
    core_op(1, 0, mk(5, 9), 2);
    core_op(0, 0, mk(6, 9), 0);
    core_op(1, 0, mk(7, 9), 1);
    core_op(1, 0, mk(8, 9), 1);
    core_op(1, 1, mk(6, 9), 3);
    core_op(1, 1, mk(9, 9), 3);
    core_op(0, 0, mk(9, 9), 2);
    // snoops: miss, M without caching, E with caching
    snoop_op(mk(44, 9), 1);
    snoop_op(mk(8, 9), 0);
    snoop_op(mk(8, 9), 1);
    snoop_op(mk(8, 9), 1);

    // R13: snoop and core together
    @(negedge clk);
    snp_valid = 1; snp_line = mk(9, 9); snp_will_cache = 0;
    req_valid = 1; req_store = 0; req_wt = 0; req_line = mk(9, 9); req_victim = 3;
    #1 check("R13 ready split", {62'b0, req_ready, snp_ready}, 64'd1);
    predict(1, 0, 0, 0, mk(9, 9), 0, emit, exp, lbl);
    @(posedge clk); #1;
    snp_valid = 0;
    check("R13 snoop served first", {3'b0, act_valid, observed()}, {3'b0, 1'b1, exp});
    predict(0, 0, 0, 0, mk(9, 9), 3, emit, exp, lbl);
    @(posedge clk); #1;
    req_valid = 0;
    check("R13 core served next", {3'b0, act_valid, observed()}, {3'b0, 1'b1, exp});

    // R14: back-pressure
    @(posedge clk); #1;
    act_ready = 0;
    core_op(0, 0, mk(11, 3), 2);
    snap = observed();
    @(negedge clk);
    req_valid = 1; req_store = 1; req_wt = 0; req_line = mk(11, 3); req_victim = 0;
    #1 check("R14 ready low on stall", {62'b0, req_ready, snp_ready}, 64'd0);
    @(posedge clk); #1;
    check("R14 held action", {3'b0, act_valid, observed()}, {3'b0, 1'b1, snap});
    @(negedge clk); act_ready = 1;
    predict(0, 1, 0, 0, mk(11, 3), 0, emit, exp, lbl);
    @(posedge clk); #1;
    req_valid = 0;
    check("R14 released request", {3'b0, act_valid, observed()}, {3'b0, 1'b1, exp});

    // R12: disabled cache bypasses, state untouched
    @(negedge clk); cache_en = 0; model_en = 0;
    core_op(0, 0, mk(11, 3), 1);
    core_op(1, 0, mk(11, 3), 1);
    core_op(1, 1, mk(77, 3), 1);
    @(negedge clk); cache_en = 1; model_en = 1;
    core_op(0, 0, mk(11, 3), 1);

    // R11: flash invalidate
    @(negedge clk); flash_inv = 1;
    #1 check("R11 ready low during flash", {62'b0, req_ready, snp_ready}, 64'd0);
    @(posedge clk); #1;
    flash_inv = 0;
    for (int s = 0; s < 128; s++) for (int w = 0; w < 4; w++) mst[s][w] = 0;
    core_op(0, 0, mk(11, 3), 2);
    check("R11 load after flash fills", {63'b0, act_fill}, 64'd1);
    snoop_op(mk(5, 9), 1);

    // constrained random mix over a small set/tag pool
    for (int i = 0; i < 600; i++) begin
      int sets[3] = '{0, 1, 127};
      logic [26:0] ln = mk($urandom_range(1, 5), sets[$urandom_range(0, 2)]);
      int kind = $urandom_range(0, 9);
      if (kind < 3) snoop_op(ln, 1'($urandom_range(0, 1)));
      else core_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ln, 2'($urandom_range(0, 3)));
    end

    finish_sim();
  end

endmodule